// File: doc/BRIEF.md
# Scatter-Gather Offset Walker

The walker turns a table of physical region descriptors into a stream of scatter-gather segments that begins at an arbitrary byte offset into the transfer. It is used when a transfer resumes partway: the controller supplies the offset and the number of descriptors, a fetch unit feeds descriptors in table order, and the walker emits (address, length) pairs for the data mover.

Each descriptor holds a 64-bit buffer address and a flags/size word whose low field stores the byte count minus one. The walker sums entry sizes until it reaches the entry that contains the offset. It trims that entry to a partial first segment and then passes every later entry through whole. A walk ends with a one-cycle completion pulse or error pulse, and a byte total is reported with the pulse. A walk is an error when the table is empty, when the offset lies past the table, or when the emitted total would exceed the largest positive 32-bit signed value.

Top module: `prdw_walker`

## Requirements
- R1: An entry's byte count is the low SIZE_W bits of `desc_flags_i` (bits 21:0 by default) plus one. The flag bits above that field have no effect on any output.
- R2: A walk started with `count_i` = 0 accepts no descriptor and emits no segment. It ends with `err_o` and `total_o` = 0.
- R3: The selected entry is the first entry i for which offset <= (sum of the sizes of entries before i) + size(i). Its segment has address = entry address + pos and length = size(i) - pos, where pos = offset - (sum of the sizes of entries before i).
- R4: Every entry after the selected one is emitted whole, as (entry address, size), in table order.
- R5: If no entry is selected after `count_i` descriptors, the walk emits no segment and ends with `err_o` and `total_o` = 0.
- R6: If adding an entry would take the emitted total above 2^31-1, that entry is not emitted and the walk ends with `err_o`. `total_o` then holds the bytes already emitted.
- R7: After all `count_i` descriptors have been consumed and every segment taken, `done_o` pulses for one cycle and `total_o` equals the sum of the emitted lengths.
- R8: While `seg_valid_o` is high and `seg_ready_i` is low, the segment stays valid and its address and length do not change.
- R9: An offset equal to the end of an entry selects that entry and yields a zero-length first segment. The next entry follows whole.
- R10: `done_o` and `err_o` are never high together, and segments are valid and descriptors are accepted only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| offset_i | input | OFF_W | Byte offset at which the transfer resumes |
| count_i | input | CNT_W | Number of descriptors in the table |
| busy_o | output | 1 | Walk in progress |
| desc_valid_i | input | 1 | Descriptor present |
| desc_ready_o | output | 1 | Descriptor accepted this cycle |
| desc_addr_i | input | ADDR_W | Descriptor buffer address |
| desc_flags_i | input | 32 | Descriptor flags/size word |
| seg_valid_o | output | 1 | Segment present |
| seg_ready_i | input | 1 | Consumer takes the segment |
| seg_addr_o | output | ADDR_W | Segment start address |
| seg_len_o | output | SIZE_W+1 | Segment length in bytes |
| done_o | output | 1 | One-cycle successful completion |
| err_o | output | 1 | One-cycle error completion |
| total_o | output | OFF_W+2 | Bytes emitted in the walk |

## Verification
Two things share one cycle: the consumer takes the held segment, and the next descriptor is accepted into the freed output stage. The descriptor-ready path depends on `seg_ready_i` in the same cycle. The bench drops `seg_ready_i` at random on most walks, so handoffs and stalls interleave in every pattern. It judges the result by comparing the full collected segment list against a model, and by checking that a stalled segment stays unchanged. The overflow walk puts the limit check into a cycle where a full-size segment is still being handed off.

// File: rtl/prdw_pkg.sv
package prdw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEEK  = 2'd1,
    ST_EMIT  = 2'd2,
    ST_DRAIN = 2'd3
  } walk_st_e;

  localparam logic [31:0] TOTAL_LIMIT = 32'h7FFF_FFFF;
endpackage

// File: rtl/prdw_size_dec.sv
module prdw_size_dec #(
  parameter int SIZE_W = 22
) (
  input  logic [31:0]     flags_i,
  output logic [SIZE_W:0] bytes_o
);
  // size field is stored minus one
  assign bytes_o = {1'b0, flags_i[SIZE_W-1:0]} + {{SIZE_W{1'b0}}, 1'b1};
endmodule

// File: rtl/prdw_locate.sv
module prdw_locate #(
  parameter int OFF_W  = 32,
  parameter int SIZE_W = 22,
  localparam int ACC_W = OFF_W + 2
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [SIZE_W:0]  size_i,
  output logic             hit_o,
  output logic [SIZE_W:0]  pos_o,
  output logic [SIZE_W:0]  rem_o
);
  logic [ACC_W-1:0] end_w, pos_w;

  assign end_w = sum_i + ACC_W'(size_i);
  assign hit_o = ACC_W'(offset_i) <= end_w;
  assign pos_w = ACC_W'(offset_i) - sum_i;
  assign pos_o = pos_w[SIZE_W:0];
  assign rem_o = size_i - pos_o;
endmodule

// File: rtl/prdw_seg_reg.sv
module prdw_seg_reg #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              space_o
);
  assign space_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      len_o   <= len_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prdw_walker.sv
module prdw_walker
  import prdw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 22,
  parameter int OFF_W  = 32,
  parameter int CNT_W  = 16,
  localparam int ACC_W = OFF_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic [31:0]       desc_flags_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [SIZE_W:0]   seg_len_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ACC_W-1:0]  total_o
);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(TOTAL_LIMIT);

  walk_st_e          st_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;
  logic [ACC_W-1:0]  sum_q, tot_q, tot_nx;
  logic              err_q, fin_q;

  logic [SIZE_W:0]   dsz, pos, rem;
  logic              hit, space, acc, last;
  logic              load;
  logic [ADDR_W-1:0] ld_addr;
  logic [SIZE_W:0]   ld_len;

  prdw_size_dec #(.SIZE_W(SIZE_W)) u_dec (
    .flags_i (desc_flags_i),
    .bytes_o (dsz)
  );

  prdw_locate #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_loc (
    .offset_i (off_q),
    .sum_i    (sum_q),
    .size_i   (dsz),
    .hit_o    (hit),
    .pos_o    (pos),
    .rem_o    (rem)
  );

  prdw_seg_reg #(.ADDR_W(ADDR_W), .LEN_W(SIZE_W + 1)) u_seg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (ld_addr),
    .len_i   (ld_len),
    .ready_i (seg_ready_i),
    .valid_o (seg_valid_o),
    .addr_o  (seg_addr_o),
    .len_o   (seg_len_o),
    .space_o (space)
  );

  assign busy_o       = (st_q != ST_IDLE);
  assign desc_ready_o = ((st_q == ST_SEEK) || (st_q == ST_EMIT)) && space;
  assign acc          = desc_valid_i && desc_ready_o;
  assign last         = (idx_q == cnt_q - CNT_W'(1));
  assign tot_nx       = tot_q + ACC_W'(dsz);

  always_comb begin
    load    = 1'b0;
    ld_addr = desc_addr_i;
    ld_len  = dsz;
    if (acc && (st_q == ST_SEEK) && hit) begin
      load    = 1'b1;
      ld_addr = desc_addr_i + ADDR_W'(pos);
      ld_len  = rem;
    end else if (acc && (st_q == ST_EMIT) && (tot_nx <= LIMIT)) begin
      load    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      off_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
      sum_q <= '0;
      tot_q <= '0;
      err_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          off_q <= offset_i;
          cnt_q <= count_i;
          idx_q <= '0;
          sum_q <= '0;
          tot_q <= '0;
          err_q <= (count_i == '0);
          st_q  <= (count_i == '0) ? ST_DRAIN : ST_SEEK;
        end
        ST_SEEK: if (acc) begin
          idx_q <= idx_q + CNT_W'(1);
          if (hit) begin
            tot_q <= ACC_W'(rem);
            st_q  <= last ? ST_DRAIN : ST_EMIT;
          end else begin
            sum_q <= sum_q + ACC_W'(dsz);
            if (last) begin
              err_q <= 1'b1;
              st_q  <= ST_DRAIN;
            end
          end
        end
        ST_EMIT: if (acc) begin
          idx_q <= idx_q + CNT_W'(1);
          if (tot_nx > LIMIT) begin
            err_q <= 1'b1;
            st_q  <= ST_DRAIN;
          end else begin
            tot_q <= tot_nx;
            if (last) st_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (space) begin
          fin_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = fin_q && !err_q;
  assign err_o   = fin_q && err_q;
  assign total_o = tot_q;
endmodule

// File: rtl/prdw_walker_chk.sv
module prdw_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 22,
  parameter int ACC_W  = 34
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              desc_ready_o,
  input logic              seg_valid_o,
  input logic              seg_ready_i,
  input logic [ADDR_W-1:0] seg_addr_o,
  input logic [SIZE_W:0]   seg_len_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ACC_W-1:0]  total_o
);
  // R8
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o));

  // R10
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R10
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o));

  // R10
  idle_no_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !desc_ready_o);

  // R10
  idle_no_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> busy_o);

  // R6
  done_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> total_o <= ACC_W'(32'h7FFF_FFFF));
endmodule

bind prdw_walker prdw_walker_chk #(
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .desc_ready_o (desc_ready_o),
  .seg_valid_o  (seg_valid_o),
  .seg_ready_i  (seg_ready_i),
  .seg_addr_o   (seg_addr_o),
  .seg_len_o    (seg_len_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .total_o      (total_o)
);

// File: tb/tb_prdw_walker.sv
module tb_prdw_walker;
  localparam int ADDR_W = 64;
  localparam int SIZE_W = 22;
  localparam int OFF_W  = 32;
  localparam int CNT_W  = 16;
  localparam int ACC_W  = OFF_W + 2;
  localparam int MAXN   = 600;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [OFF_W-1:0]  offset_i = '0;
  logic [CNT_W-1:0]  count_i = '0;
  logic              busy_o;
  logic              desc_valid_i = 1'b0;
  logic              desc_ready_o;
  logic [ADDR_W-1:0] desc_addr_i = '0;
  logic [31:0]       desc_flags_i = '0;
  logic              seg_valid_o;
  logic              seg_ready_i = 1'b0;
  logic [ADDR_W-1:0] seg_addr_o;
  logic [SIZE_W:0]   seg_len_o;
  logic              done_o, err_o;
  logic [ACC_W-1:0]  total_o;

  always #2 clk = ~clk;

  prdw_walker dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .offset_i(offset_i),
    .count_i(count_i), .busy_o(busy_o), .desc_valid_i(desc_valid_i),
    .desc_ready_o(desc_ready_o), .desc_addr_i(desc_addr_i),
    .desc_flags_i(desc_flags_i), .seg_valid_o(seg_valid_o),
    .seg_ready_i(seg_ready_i), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .done_o(done_o), .err_o(err_o), .total_o(total_o)
  );

  int checks = 0;
  int errors = 0;

  logic [63:0] e_addr [MAXN];
  logic [31:0] e_flg  [MAXN];
  logic [63:0] x_addr [MAXN];
  logic [63:0] x_len  [MAXN];
  logic [63:0] g_addr [MAXN];
  logic [63:0] g_len  [MAXN];
  int          x_n, g_n;
  bit          x_err;
  logic [63:0] x_tot;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] esz(input logic [31:0] f);
    return 64'(f[SIZE_W-1:0]) + 64'd1;
  endfunction

  task automatic model(input int n, input logic [31:0] off);
    logic [63:0] sum, pos, sz;
    int found;
    x_n = 0; x_err = 0; x_tot = 0; sum = 0; found = -1; pos = 0;
    if (n == 0) begin x_err = 1; return; end
    for (int i = 0; i < n; i++) begin
      sz = esz(e_flg[i]);
      if (64'(off) <= sum + sz) begin found = i; pos = 64'(off) - sum; break; end
      sum += sz;
    end
    if (found < 0) begin x_err = 1; return; end
    x_addr[0] = e_addr[found] + pos;
    x_len[0]  = esz(e_flg[found]) - pos;
    x_tot = x_len[0]; x_n = 1;
    for (int j = found + 1; j < n; j++) begin
      sz = esz(e_flg[j]);
      if (x_tot + sz > 64'h7FFF_FFFF) begin x_err = 1; return; end
      x_addr[x_n] = e_addr[j]; x_len[x_n] = sz; x_tot += sz; x_n++;
    end
  endtask

  task automatic walk(input int n, input logic [31:0] off, input bit stall,
                      input string tag);
    int idx;
    bit fd, hold;
    logic [63:0] h_addr, h_len;
    bit g_err;
    logic [63:0] g_tot;
    model(n, off);
    g_n = 0; idx = 0; hold = 0; h_addr = 0; h_len = 0; g_err = 0; g_tot = 0;
    @(negedge clk);
    start_i = 1'b1; offset_i = off; count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      if (done_o || err_o) begin
        g_err = err_o; g_tot = 64'(total_o);
        break;
      end
      if (hold)
        chk(seg_valid_o && seg_addr_o == h_addr && 64'(seg_len_o) == h_len,
            "R8", "stalled segment", seg_addr_o, h_addr);
      desc_valid_i = (idx < n);
      desc_addr_i  = (idx < n) ? e_addr[idx] : '0;
      desc_flags_i = (idx < n) ? e_flg[idx] : '0;
      seg_ready_i  = stall ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (seg_valid_o && seg_ready_i && g_n < MAXN) begin
        g_addr[g_n] = seg_addr_o; g_len[g_n] = 64'(seg_len_o); g_n++;
      end
      fd = desc_valid_i && desc_ready_o;
      hold = seg_valid_o && !seg_ready_i;
      h_addr = seg_addr_o; h_len = 64'(seg_len_o);
      @(posedge clk);
      if (fd) idx++;
      @(negedge clk);
    end
    desc_valid_i = 1'b0; seg_ready_i = 1'b0;
    chk(g_n == x_n, tag, "segment count", 64'(g_n), 64'(x_n));
    for (int i = 0; i < g_n && i < x_n; i++) begin
      chk(g_addr[i] == x_addr[i], tag, "segment address", g_addr[i], x_addr[i]);
      chk(g_len[i] == x_len[i], tag, "segment length", g_len[i], x_len[i]);
    end
    chk(g_err == x_err, tag, "error outcome", 64'(g_err), 64'(x_err));
    chk(g_tot == x_tot, tag, "byte total", g_tot, x_tot);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    logic [63:0] tot;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !seg_valid_o && !done_o && !err_o && !desc_ready_o,
        "R10", "reset outputs", {60'd0, busy_o, seg_valid_o, done_o, err_o}, 64'd0);

    // R1: upper flag bits set, size field 9 -> 10 bytes
    e_addr[0] = 64'h1000; e_flg[0] = 32'hFFC0_0009;
    e_addr[1] = 64'h2000; e_flg[1] = 32'h8000_0013;
    walk(2, 32'd4, 1'b0, "R1");

    // R2: empty table
    walk(0, 32'd0, 1'b0, "R2");

    // R3/R4: offset inside third entry
    for (int i = 0; i < 5; i++) begin
      e_addr[i] = 64'hA000_0000_0000 + 64'(i) * 64'h1_0000; e_flg[i] = 32'd99;
    end
    walk(5, 32'd250, 1'b1, "R3");
    walk(5, 32'd0, 1'b1, "R4");

    // R9: offset on an entry boundary -> zero-length first segment
    e_addr[0] = 64'h100; e_flg[0] = 32'd99;
    e_addr[1] = 64'h900; e_flg[1] = 32'd199;
    walk(2, 32'd100, 1'b0, "R9");

    // R5: offset past the table
    walk(2, 32'd301, 1'b0, "R5");

    // R6: total crosses 2^31-1 on entry 512
    for (int i = 0; i < 520; i++) begin
      e_addr[i] = 64'(i) << 24; e_flg[i] = 32'h003F_FFFF;
    end
    walk(520, 32'd0, 1'b0, "R6");

    // R7: random tables, random offsets, random stalls
    for (int w = 0; w < 40; w++) begin
      n = 1 + int'($urandom % 12);
      tot = 0;
      for (int i = 0; i < n; i++) begin
        e_addr[i] = {$urandom, $urandom};
        e_flg[i]  = ($urandom & 32'hFFC0_0000) | ($urandom % 3000);
        tot += esz(e_flg[i]);
      end
      walk(n, 32'($urandom % (32'(tot) + 40)), 1'b1, "R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule